// File: doc/BRIEF.md
# Quadrature-Phase Timestamp Interpolator

This block time-stamps an asynchronous event edge with a resolution far finer than one reference clock period. A free-running coarse counter runs on the reference clock. The event passes through a short flip-flop synchroniser, and the first synchronised rising edge latches that counter. Two reference sinewaves in quadrature run at one tenth of the clock rate. An external converter samples both of them at the raw event edge and hands the signed pair to the block.

An iterative CORDIC in vectoring mode turns the pair into a four-quadrant angle. A programmable offset is subtracted from that angle, so the result is measured from the start of a counter-aligned sinewave cycle. The phase is also mapped onto tenths of a period. The block then works out which counter tick the event fell in, using the known synchroniser latency window, and from that tick it finds the sinewave cycle that was sampled. The output stamp has the whole cycle index in its upper bits and the 16-bit phase in its lower bits. One stamp unit is therefore 1/65536 of a sinewave period.

A second edge that arrives while a stamp is still being produced is reported on a one-cycle overrun strobe and then discarded.

Top module: `quad_stamp_interp`

## Requirements
- R1: The coarse count is cycle_index*10 + tick, with the tick running 0..9. The count latched for an event is the count in the cycle where the synchronised rising edge appears. That edge appears SYNC_STAGES counts after the count during which the event input rose, and it lasts one cycle.
- R2: The fine phase is atan2(Q, I) in units of 1/65536 of a period, computed from the 12-bit two's-complement sample pair. Its error is no more than 16 units (1/4096 of a period).
- R3: The stamp equals cycle_index*65536 + phase, where the event occurred at count n and 10*cycle_index <= n < 10*cycle_index + 10. This stays true at every tick position inside a cycle and across cycle boundaries, so no whole-cycle slips occur.
- R4: phase_off is subtracted from the raw angle modulo 65536 before the result is used. The stamp is correct for any offset value, including offsets that make the difference wrap.
- R5: stamp_valid is a single-cycle pulse. It is high during the 18th cycle after the cycle in which smp_valid was accepted. smp_valid is accepted when it is high while an event is waiting for samples.
- R6: A synchronised edge that appears while the block is waiting for samples or computing raises overrun for exactly the following cycle. That event produces no stamp, and the job already in progress completes unchanged.
- R7: smp_valid has no effect when no event is waiting for samples. No stamp follows it.
- R8: While reset is asserted, stamp_valid, overrun and stamp are all zero.
- R9: A synchronised edge that appears in the same cycle as stamp_valid is accepted as a new event. An edge one cycle earlier is treated as an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (the sinewaves run at clk/10) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_async | input | 1 | Raw event input, asynchronous to clk; its rising edge is stamped |
| smp_valid | input | 1 | Sample pair present on smp_i/smp_q this cycle |
| smp_i | input | 12 | In-phase sample, two's complement |
| smp_q | input | 12 | Quadrature sample, two's complement |
| phase_off | input | 16 | Calibrated phase of a counter-aligned cycle start |
| stamp_valid | output | 1 | One-cycle strobe, stamp is new |
| stamp | output | 48 | Cycle index [47:16] and phase [15:0] |
| overrun | output | 1 | One-cycle strobe, an edge was dropped while busy |

## Verification
Two functions can coincide in one cycle: the delivery of a finished stamp and the detection of the next synchronised edge. The stimulus times a second event so that its synchronised edge lands exactly in the stamp_valid cycle, and in a separate case one cycle earlier. The cycle-by-cycle model expects the first case to start a new job whose stamp must later be correct. It expects the second case to raise overrun, produce no stamp, and leave a later sample strobe without effect. Stamps from events placed at every tick position, at fractions near 0 and 1, and under random offsets are compared with the ideal time to within 16 units.

// File: rtl/qsi_pkg.sv
`timescale 1ns/1ps
package qsi_pkg;

  localparam int ANG_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CALC = 2'd2
  } qsi_state_e;

  // atan(2^-k) scaled so that 65536 is one full turn
  function automatic logic [ANG_W-1:0] atan_step(input int unsigned k);
    case (k)
      0:       atan_step = 16'd8192;
      1:       atan_step = 16'd4836;
      2:       atan_step = 16'd2555;
      3:       atan_step = 16'd1297;
      4:       atan_step = 16'd651;
      5:       atan_step = 16'd326;
      6:       atan_step = 16'd163;
      7:       atan_step = 16'd81;
      8:       atan_step = 16'd41;
      9:       atan_step = 16'd20;
      10:      atan_step = 16'd10;
      11:      atan_step = 16'd5;
      12:      atan_step = 16'd3;
      13:      atan_step = 16'd1;
      14:      atan_step = 16'd1;
      default: atan_step = 16'd0;
    endcase
  endfunction

endpackage

// File: rtl/qsi_sync.sv
`timescale 1ns/1ps
module qsi_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              tail_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign chain_d[g] = async_in;
    end else begin : g_next
      assign chain_d[g] = chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      tail_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      tail_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~tail_q;

  // R1: an edge is only reported after the input was high STAGES edges back
  assert_rise_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> $past(async_in, STAGES));

  // R1: the synchronised edge lasts one cycle
  assert_rise_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/qsi_coarse.sv
`timescale 1ns/1ps
module qsi_coarse #(
  parameter int TICKS = 10,
  parameter int CYC_W = 32,
  localparam int SUB_W = $clog2(TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CYC_W-1:0] cyc,
  output logic [SUB_W-1:0] sub
);

  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             wrap;

  always_comb begin
    wrap = (sub_q == SUB_W'(TICKS - 1));
    if (wrap) begin
      sub_d = '0;
      cyc_d = cyc_q + 1'b1;
    end else begin
      sub_d = sub_q + 1'b1;
      cyc_d = cyc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      sub_q <= '0;
    end else begin
      cyc_q <= cyc_d;
      sub_q <= sub_d;
    end
  end

  assign cyc = cyc_q;
  assign sub = sub_q;

  assert_sub_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sub_q < SUB_W'(TICKS));

  assert_sub_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_q == SUB_W'(TICKS - 1)) |=> (sub_q == '0 && cyc_q == $past(cyc_q) + 1'b1));

endmodule

// File: rtl/qsi_cordic.sv
`timescale 1ns/1ps
module qsi_cordic
  import qsi_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int GUARD = 6,
  parameter int ITER  = 16,
  localparam int W     = IN_W + GUARD + 2,
  localparam int CNT_W = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IN_W-1:0]  i_in,
  input  logic [IN_W-1:0]  q_in,
  output logic             done,
  output logic [ANG_W-1:0] angle
);

  logic signed [W-1:0] x_q, x_d, y_q, y_d;
  logic [ANG_W-1:0]    z_q, z_d;
  logic [CNT_W-1:0]    k_q, k_d;
  logic                act_q, act_d;
  logic                done_q, done_d;

  logic signed [W-1:0] x_ld, y_ld, sx, sy;
  logic [ANG_W-1:0]    step;

  always_comb begin
    x_ld = {{(W-IN_W-GUARD){i_in[IN_W-1]}}, i_in, {GUARD{1'b0}}};
    y_ld = {{(W-IN_W-GUARD){q_in[IN_W-1]}}, q_in, {GUARD{1'b0}}};
    sx   = x_q >>> k_q;
    sy   = y_q >>> k_q;
    step = atan_step(32'(k_q));

    x_d    = x_q;
    y_d    = y_q;
    z_d    = z_q;
    k_d    = k_q;
    act_d  = act_q;
    done_d = 1'b0;

    if (start) begin
      // fold the left half-plane onto the right one, adding half a turn
      if (x_ld[W-1]) begin
        x_d = -x_ld;
        y_d = -y_ld;
        z_d = ANG_W'(1) << (ANG_W - 1);
      end else begin
        x_d = x_ld;
        y_d = y_ld;
        z_d = '0;
      end
      k_d   = '0;
      act_d = 1'b1;
    end else if (act_q) begin
      if (!y_q[W-1]) begin
        x_d = x_q + sy;
        y_d = y_q - sx;
        z_d = z_q + step;
      end else begin
        x_d = x_q - sy;
        y_d = y_q + sx;
        z_d = z_q - step;
      end
      if (k_q == CNT_W'(ITER - 1)) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        k_d = k_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      k_q    <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      x_q    <= x_d;
      y_q    <= y_d;
      z_q    <= z_d;
      k_q    <= k_d;
      act_q  <= act_d;
      done_q <= done_d;
    end
  end

  assign done  = done_q;
  assign angle = z_q;

  // R2: the folded vector stays in the right half-plane while rotating
  assert_xpos_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> !x_q[W-1]);

  // R5: completion follows an active iteration and lasts one cycle
  assert_done_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(act_q));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/quad_stamp_interp.sv
`timescale 1ns/1ps
module quad_stamp_interp
  import qsi_pkg::*;
#(
  parameter int SYNC_STAGES = 3,
  parameter int TICKS       = 10,
  parameter int CYC_W       = 32,
  parameter int SMP_W       = 12,
  parameter int GUARD       = 6,
  parameter int ITER        = 16,
  localparam int SUB_W   = $clog2(TICKS),
  localparam int LAT_MAX = SYNC_STAGES + 1,
  localparam int STAMP_W = CYC_W + ANG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_async,
  input  logic               smp_valid,
  input  logic [SMP_W-1:0]   smp_i,
  input  logic [SMP_W-1:0]   smp_q,
  input  logic [ANG_W-1:0]   phase_off,
  output logic               stamp_valid,
  output logic [STAMP_W-1:0] stamp,
  output logic               overrun
);

  logic             rise;
  logic [CYC_W-1:0] cnt_cyc;
  logic [SUB_W-1:0] cnt_sub;
  logic             cdc_done;
  logic [ANG_W-1:0] raw_ang;

  qsi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (evt_async),
    .rise     (rise)
  );

  qsi_coarse #(.TICKS(TICKS), .CYC_W(CYC_W)) u_coarse (
    .clk   (clk),
    .rst_n (rst_n),
    .cyc   (cnt_cyc),
    .sub   (cnt_sub)
  );

  qsi_state_e       st_q, st_d;
  logic             start, cap_en, fin;
  logic [CYC_W-1:0] cap_cyc_q;
  logic [SUB_W-1:0] cap_sub_q;

  assign cap_en = rise && (st_q == ST_IDLE);
  assign start  = smp_valid && (st_q == ST_WAIT);
  assign fin    = cdc_done && (st_q == ST_CALC);

  qsi_cordic #(.IN_W(SMP_W), .GUARD(GUARD), .ITER(ITER)) u_cordic (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .i_in  (smp_i),
    .q_in  (smp_q),
    .done  (cdc_done),
    .angle (raw_ang)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (rise)      st_d = ST_WAIT;
      ST_WAIT: if (smp_valid) st_d = ST_CALC;
      ST_CALC: if (cdc_done)  st_d = ST_IDLE;
      default:                st_d = ST_IDLE;
    endcase
  end

  // cycle resolution: oldest count the event could have had, then the
  // unique count in the latency window whose tick matches the phase
  logic [ANG_W-1:0] fine;
  logic [SUB_W-1:0] tenth, b_sub;
  logic [CYC_W-1:0] b_cyc, cyc_sel;

  always_comb begin
    fine  = raw_ang - phase_off;
    tenth = SUB_W'(((ANG_W+SUB_W)'(fine) * (ANG_W+SUB_W)'(TICKS)) >> ANG_W);
    if (cap_sub_q >= SUB_W'(LAT_MAX)) begin
      b_sub = cap_sub_q - SUB_W'(LAT_MAX);
      b_cyc = cap_cyc_q;
    end else begin
      b_sub = cap_sub_q + SUB_W'(TICKS - LAT_MAX);
      b_cyc = cap_cyc_q - 1'b1;
    end
    cyc_sel = b_cyc + CYC_W'(tenth < b_sub);
  end

  logic               sv_q, ov_q;
  logic [STAMP_W-1:0] stamp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cap_cyc_q <= '0;
      cap_sub_q <= '0;
      stamp_q   <= '0;
      sv_q      <= 1'b0;
      ov_q      <= 1'b0;
    end else begin
      st_q <= st_d;
      sv_q <= fin;
      ov_q <= rise && (st_q != ST_IDLE);
      if (cap_en) begin
        cap_cyc_q <= cnt_cyc;
        cap_sub_q <= cnt_sub;
      end
      if (fin) begin
        stamp_q <= {cyc_sel, fine};
      end
    end
  end

  assign stamp_valid = sv_q;
  assign stamp       = stamp_q;
  assign overrun     = ov_q;

  assert_tenth_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (tenth < SUB_W'(TICKS)));

  assert_sv_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sv_q |=> !sv_q);

  assert_ov_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |-> $past(st_q != ST_IDLE));

  assert_ov_keeps_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |-> ($stable(cap_cyc_q) && $stable(cap_sub_q)));

  assert_ov_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |=> !ov_q);

endmodule

// File: tb/tb_quad_stamp_interp.sv
`timescale 1ns/1ps
module tb_quad_stamp_interp;

  localparam int  CLK_PERIOD = 100;
  localparam int  N          = 3;
  localparam real UNITS      = 6553.6;   // stamp units per counter tick
  localparam real TOL        = 16.0;
  localparam real TWO_PI     = 6.283185307179586;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt = 1'b0;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_i = '0;
  logic [11:0] smp_q = '0;
  logic [15:0] phase_off = '0;
  logic        stamp_valid;
  logic [47:0] stamp;
  logic        overrun;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_stamp_interp #(.SYNC_STAGES(N)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_async   (evt),
    .smp_valid   (smp_valid),
    .smp_i       (smp_i),
    .smp_q       (smp_q),
    .phase_off   (phase_off),
    .stamp_valid (stamp_valid),
    .stamp       (stamp),
    .overrun     (overrun)
  );

  int  checks = 0;
  int  errors = 0;
  int  tick = 0;
  real theta = 0.0;

  int  det_q[$];
  real exp_q[$];

  // behavioural model: 0 idle, 1 waiting for samples, 2 computing
  int  mst = 0;
  int  left = 0;
  real mexp = 0.0;
  real done_exp = 0.0;
  bit  exp_sv = 1'b0;
  bit  exp_ov = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      tick = 0; mst = 0; left = 0; exp_sv = 1'b0; exp_ov = 1'b0;
    end else begin
      int  pc;
      bit  rz;
      real re;
      pc = tick;
      tick = tick + 1;
      rz = 1'b0;
      re = 0.0;
      if (det_q.size() > 0 && det_q[0] == pc) begin
        rz = 1'b1;
        void'(det_q.pop_front());
        re = exp_q.pop_front();
      end
      exp_sv = 1'b0;
      exp_ov = 1'b0;
      case (mst)
        0: if (rz) begin mst = 1; mexp = re; end
        1: begin
          if (rz) exp_ov = 1'b1;
          if (smp_valid) begin mst = 2; left = 17; end
        end
        default: begin
          if (rz) exp_ov = 1'b1;
          left = left - 1;
          if (left == 0) begin mst = 0; exp_sv = 1'b1; done_exp = mexp; end
        end
      endcase
    end
  end

  task automatic report(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (tick %0d)", req, what, act, expv, tick);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && tick > 0) begin
      // R5 R7 R9: strobe must appear exactly when the model expects it
      report(stamp_valid == exp_sv, "R5", "stamp_valid", longint'(stamp_valid), longint'(exp_sv));
      report(overrun == exp_ov, "R6", "overrun", longint'(overrun), longint'(exp_ov));
      if (exp_sv && stamp_valid) begin
        real act, d;
        act = real'(stamp);
        d = act - done_exp;
        if (d < 0.0) d = -d;
        if (d > 1000.0)
          report(1'b0, "R3", "cycle slip stamp", longint'(stamp), longint'($rtoi(done_exp)));
        else
          // R1 R2 R4: latency, phase accuracy and offset all land here
          report(d <= TOL, "R2", "stamp error", longint'(stamp), longint'($rtoi(done_exp)));
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_off(input int th);
    theta = real'(th);
    phase_off = th[15:0];
  endtask

  task automatic evt_up(input real frac, output real e);
    e = real'(tick) + frac;
    det_q.push_back(tick + N);   // R1: edge visible N counts later
    exp_q.push_back(e * UNITS);
    evt = 1'b1;
  endtask

  task automatic send_smp(input real e);
    real ang;
    int  iv, qv;
    ang = TWO_PI * (theta + e * UNITS) / 65536.0;
    iv = $rtoi($floor(2000.0 * $cos(ang) + 0.5));
    qv = $rtoi($floor(2000.0 * $sin(ang) + 0.5));
    smp_i = iv[11:0];
    smp_q = qv[11:0];
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic single(input real frac, input int sd);
    real e;
    evt_up(frac, e);
    wait_n(N + 1 + sd);
    evt = 1'b0;
    send_smp(e);
    wait_n(24);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R5 watchdog: actual %0d cycles expected fewer than %0d", tick, 200000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    real e1, e2;
    repeat (3) @(negedge clk);
    // R8: reset values
    report(stamp_valid == 1'b0, "R8", "stamp_valid in reset", longint'(stamp_valid), 0);
    report(overrun == 1'b0, "R8", "overrun in reset", longint'(overrun), 0);
    report(stamp == '0, "R8", "stamp in reset", longint'(stamp), 0);
    rst_n = 1'b1;
    wait_n(20);

    // R1 R3: every tick position within a cycle, fractions at both ends
    set_off(12345);
    for (int j = 0; j < 10; j++) begin
      wait_n(j);
      single(0.001, 0);
      single(0.999, j % 4);
      single(0.5, 1);
    end

    // R4: offsets at the wrap points
    set_off(0);
    single(0.25, 2);
    set_off(65535);
    single(0.75, 0);
    single(0.0, 3);

    // R2 R4: random offsets, fractions and sample delays
    for (int j = 0; j < 30; j++) begin
      set_off(int'($urandom_range(0, 65535)));
      wait_n(int'($urandom_range(0, 9)));
      single(real'($urandom_range(0, 999)) / 1000.0, int'($urandom_range(0, 3)));
    end

    // R7: sample strobe with nothing waiting
    wait_n(7);
    send_smp(3.3);
    wait_n(25);

    // R6: second edge while computing is dropped
    set_off(40000);
    evt_up(0.3, e1);
    wait_n(N + 1);
    evt = 1'b0;
    send_smp(e1);
    wait_n(5);
    evt_up(0.6, e2);
    wait_n(3);
    evt = 1'b0;
    wait_n(30);

    // R9: next edge lands in the stamp_valid cycle and is accepted
    evt_up(0.45, e1);
    wait_n(N + 1);
    evt = 1'b0;
    send_smp(e1);
    wait_n(17 - N);
    evt_up(0.8, e2);
    wait_n(N + 1);
    evt = 1'b0;
    send_smp(e2);
    wait_n(24);

    // R9 R6 R7: one cycle earlier it is an overrun, later samples ignored
    evt_up(0.15, e1);
    wait_n(N + 1);
    evt = 1'b0;
    send_smp(e1);
    wait_n(16 - N);
    evt_up(0.9, e2);
    wait_n(N + 1);
    evt = 1'b0;
    send_smp(e2);
    wait_n(30);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule